// File: doc/BRIEF.md
# CCD Readout Clamp and Blanking Sequencer

This block follows the position of a CCD readout, one pixel clock at a time. It keeps a pixel counter that a line-start pulse clears, and a line counter that a frame-start pulse clears and each line-start pulse advances. Both counters hold at a saturation value when no start pulse arrives. From the line number it picks one of three horizontal sequences: vertical blanking, vertical optical-black, or effective readout. From that sequence and the pixel number it drives two strobes for the analog front end. The first is the optical-black clamp strobe, which lets the black-level loop sample shielded pixels. The second is the pixel-blanking strobe, which marks pixels that carry no valid data.

A line is made of four horizontal regions, in this order: dummy positions from the horizontal register, front optical-black pixels, active pixels, and trailing optical-black pixels. A frame is made of four vertical regions, in this order: front optical-black lines, effective lines, back optical-black lines, and blanking lines. Every region size is an elaboration-time parameter. The counts, the sequence code and both strobes are registered together, so the strobes always match the counts shown in the same cycle.

Top module: `clamp_blank_seq`

## Requirements
- R1: The pixel count becomes 0 on the clock after a line-start pulse. Otherwise it rises by one per clock until it reaches LINE_PIX (the sum of all four horizontal region sizes), and then it holds at that value.
- R2: The line count becomes 0 on the clock after a frame-start pulse, including when a line-start pulse arrives in the same cycle. A line-start pulse alone raises it by one, up to FRAME_LINES (the sum of all four vertical region sizes), where it then holds.
- R3: Line numbers below FOB_LINES are optical-black lines. The next EFF_LINES lines are effective lines. The next BOB_LINES lines are optical-black lines. Every higher line number, including the saturated value, is a blanking line.
- R4: The sequence code is 2'b00 for blanking, 2'b01 for optical-black lines and 2'b10 for effective lines. It is loaded from the new line count only when a line-start pulse arrives. A frame-start pulse alone leaves it unchanged.
- R5: On blanking lines the clamp strobe is low and the blanking strobe is high at every pixel position.
- R6: On optical-black lines the clamp strobe is high at every pixel position, including the saturated count, and the blanking strobe is low.
- R7: On effective lines the blanking strobe is low. The clamp strobe is high only for pixel counts from LINE_PIX-BOB_PIX to LINE_PIX-1, which are the trailing optical-black pixels. It is low on dummy, front optical-black and active pixels, and at the saturated count.
- R8: Every output is registered. The strobes in a cycle belong to the pixel count and sequence code shown in that same cycle, and all outputs respond one clock after the start pulses are sampled.
- R9: While reset is high, the pixel count reads LINE_PIX, the line count reads FRAME_LINES, the sequence code reads 2'b00, the clamp strobe is low and the blanking strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | One-cycle pulse at the first pixel of a line |
| frame_start | input | 1 | One-cycle pulse that clears the line count |
| clpob | output | 1 | Optical-black clamp strobe |
| pblk | output | 1 | Pixel-blanking strobe |
| seq_sel | output | 2 | Current horizontal sequence code |
| pix_count | output | PIX_W | Pixel position within the line |
| line_count | output | LINE_W | Line position within the frame |

## Verification
The bench builds the block with small regions: 3 dummy, 2 front optical-black, 5 active and 3 trailing optical-black pixels, which gives 13 per line. It uses 2 front optical-black lines, 3 effective lines, 1 back optical-black line and 2 blanking lines, which gives 8 per frame. With these sizes a whole frame, both counter saturation points and every region edge fit into a few hundred cycles. This covers a line that runs past its last pixel and lines that go past the last blanking line. It also covers a frame-start pulse that arrives in the middle of a line, which must leave the sequence code untouched.

// File: rtl/clamp_blank_seq.sv
module clamp_blank_seq #(
  parameter int DUMMY_PIX   = 28,
  parameter int FOB_PIX     = 4,
  parameter int ACTIVE_PIX  = 640,
  parameter int BOB_PIX     = 48,
  parameter int FOB_LINES   = 10,
  parameter int EFF_LINES   = 480,
  parameter int BOB_LINES   = 2,
  parameter int VBLK_LINES  = 20,
  localparam int LINE_PIX    = DUMMY_PIX + FOB_PIX + ACTIVE_PIX + BOB_PIX,
  localparam int FRAME_LINES = FOB_LINES + EFF_LINES + BOB_LINES + VBLK_LINES,
  localparam int PIX_W       = $clog2(LINE_PIX + 1),
  localparam int LINE_W      = $clog2(FRAME_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              frame_start,
  output logic              clpob,
  output logic              pblk,
  output logic [1:0]        seq_sel,
  output logic [PIX_W-1:0]  pix_count,
  output logic [LINE_W-1:0] line_count
);
  localparam logic [PIX_W-1:0]  PIX_SAT   = PIX_W'(LINE_PIX);
  localparam logic [PIX_W-1:0]  TAIL_OB   = PIX_W'(LINE_PIX - BOB_PIX);
  localparam logic [LINE_W-1:0] LINE_SAT  = LINE_W'(FRAME_LINES);
  localparam logic [LINE_W-1:0] FOB_END   = LINE_W'(FOB_LINES);
  localparam logic [LINE_W-1:0] EFF_END   = LINE_W'(FOB_LINES + EFF_LINES);
  localparam logic [LINE_W-1:0] BOB_END   = LINE_W'(FOB_LINES + EFF_LINES + BOB_LINES);

  localparam logic [1:0] SEQ_BLANK = 2'b00;
  localparam logic [1:0] SEQ_OB    = 2'b01;
  localparam logic [1:0] SEQ_EFF   = 2'b10;

  logic [PIX_W-1:0]  pix_nxt;
  logic [LINE_W-1:0] line_nxt;
  logic [1:0]        region, seq_nxt;
  logic              clpob_nxt;

  assign pix_nxt  = line_start ? '0 :
                    (pix_count == PIX_SAT) ? pix_count : pix_count + 1'b1;
  assign line_nxt = frame_start ? '0 :
                    (line_start && line_count != LINE_SAT) ? line_count + 1'b1 : line_count;

  always_comb begin
    if (line_nxt < FOB_END)      region = SEQ_OB;
    else if (line_nxt < EFF_END) region = SEQ_EFF;
    else if (line_nxt < BOB_END) region = SEQ_OB;
    else                         region = SEQ_BLANK;
  end

  assign seq_nxt = line_start ? region : seq_sel;

  always_comb begin
    case (seq_nxt)
      SEQ_OB:  clpob_nxt = 1'b1;
      SEQ_EFF: clpob_nxt = (pix_nxt >= TAIL_OB) && (pix_nxt != PIX_SAT);
      default: clpob_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_count  <= PIX_SAT;
      line_count <= LINE_SAT;
      seq_sel    <= SEQ_BLANK;
      clpob      <= 1'b0;
      pblk       <= 1'b1;
    end else begin
      pix_count  <= pix_nxt;
      line_count <= line_nxt;
      seq_sel    <= seq_nxt;
      clpob      <= clpob_nxt;
      pblk       <= (seq_nxt == SEQ_BLANK);
    end
  end

  // R1
  pix_clear_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> pix_count == '0);

  // R1
  pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_count == PIX_SAT && !line_start) |=> pix_count == PIX_SAT);

  // R2
  line_clear_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> line_count == '0);

  // R4
  seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(seq_sel));

  // R5
  blank_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    seq_sel == SEQ_BLANK |-> (!clpob && pblk));

  // R6
  ob_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    seq_sel == SEQ_OB |-> (clpob && !pblk));

  // R7
  eff_front_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == SEQ_EFF && pix_count < TAIL_OB) |-> (!clpob && !pblk));
endmodule

// File: tb/test_clamp_blank_seq.sv
module test_clamp_blank_seq;
  localparam int DP = 3, FP = 2, AP = 5, BP = 3;
  localparam int FL = 2, EL = 3, BL = 1, VL = 2;
  localparam int LPIX = DP + FP + AP + BP;
  localparam int FLINES = FL + EL + BL + VL;
  localparam int PW = $clog2(LPIX + 1);
  localparam int LW = $clog2(FLINES + 1);

  typedef struct {
    int pix; int line; int seq; bit clp; bit blk;
  } exp_t;

  logic clk = 0, rst = 1, line_start = 0, frame_start = 0;
  logic clpob, pblk;
  logic [1:0] seq_sel;
  logic [PW-1:0] pix_count;
  logic [LW-1:0] line_count;

  int checks = 0, errors = 0;
  exp_t q[$];
  int m_pix = LPIX, m_line = FLINES, m_seq = 0;

  clamp_blank_seq #(.DUMMY_PIX(DP), .FOB_PIX(FP), .ACTIVE_PIX(AP), .BOB_PIX(BP),
                    .FOB_LINES(FL), .EFF_LINES(EL), .BOB_LINES(BL), .VBLK_LINES(VL))
    i_clamp_blank_seq (.clk, .rst, .line_start, .frame_start, .clpob, .pblk,
                       .seq_sel, .pix_count, .line_count);

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic int region(input int ln);
    if (ln < FL) return 1;
    if (ln < FL + EL) return 2;
    if (ln < FL + EL + BL) return 1;
    return 0;
  endfunction

  function automatic exp_t make_exp();
    exp_t e;
    e.pix = m_pix; e.line = m_line; e.seq = m_seq;
    e.blk = (m_seq == 0);
    e.clp = (m_seq == 1) || (m_seq == 2 && m_pix >= LPIX - BP && m_pix < LPIX);
    return e;
  endfunction

  // one line of n pixel clocks, optional frame start on its first clock
  task automatic run_line(input bit fs, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_start  = (i == 0);
      frame_start = fs && (i == 0);
      if (i == 0) begin
        m_pix  = 0;
        m_line = fs ? 0 : (m_line < FLINES ? m_line + 1 : FLINES);
        m_seq  = region(m_line);
      end else if (m_pix < LPIX) m_pix++;
      q.push_back(make_exp());
      @(posedge clk);
    end
    @(negedge clk);
    line_start = 0; frame_start = 0;
  endtask

  // frame start alone: line count clears, sequence code held (R4)
  task automatic frame_only(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_start = 0;
      frame_start = (i == 0);
      if (i == 0) m_line = 0;
      if (m_pix < LPIX) m_pix++;
      q.push_back(make_exp());
      @(posedge clk);
    end
    @(negedge clk);
    frame_start = 0;
  endtask

  // monitor: R8 outputs compared one clock after the inputs were applied
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t e;
      string sreq;
      e = q.pop_front();
      sreq = (e.seq == 0) ? "R5" : (e.seq == 1) ? "R6" : "R7";
      chk("R1 pix_count", int'(pix_count), e.pix);
      chk("R2 line_count", int'(line_count), e.line);
      chk("R3/R4 seq_sel", int'(seq_sel), e.seq);
      chk({sreq, " R8 clpob"}, int'(clpob), int'(e.clp));
      chk({sreq, " pblk"}, int'(pblk), int'(e.blk));
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset pix_count", int'(pix_count), LPIX);
        chk("R9 reset line_count", int'(line_count), FLINES);
        chk("R9 reset seq_sel", int'(seq_sel), 0);
        chk("R9 reset clpob", int'(clpob), 0);
        chk("R9 reset pblk", int'(pblk), 1);
        @(negedge clk); rst = 0;
        run_line(0, 5);                       // R2 saturated line stays blanking
        run_line(1, LPIX);                    // line 0, frame start with line start
        for (int l = 1; l < FLINES + 2; l++)  // whole frame and past saturation
          run_line(0, LPIX);
        run_line(1, LPIX + 3);                // R1 pixel saturation on OB line
        run_line(0, LPIX);
        run_line(0, LPIX + 4);                // R7 effective line, saturated pixel
        frame_only(3);                        // R4 seq held, line cleared
        run_line(0, LPIX);
        run_line(0, LPIX);
        repeat (3) @(posedge clk);
        #2;
        chk("R8 queue drained", q.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule